// File: doc/BRIEF.md
# PLL Frequency Calculator

This block works out, from configuration words, the frequency in hertz that a clock generator's PLL would produce and the frequency of the peripheral bus clock derived from it. A request presents a PLL parameter word, a clock-select word, a mode bit and three strap inputs together with a one-cycle `start`. The block latches them and runs a short sequence of steps: input-clock choice, field unpacking, multiplier, product and bus division. It answers with a one-cycle `done` pulse, and in that same cycle both results are valid.

Two parameter-word layouts are understood. In programmed mode (`mode` = 0) the word either selects a fixed frequency from a strap-indexed table or describes an N/OD/D loop. In M/N/P mode (`mode` = 1) it carries M, N and P fields. Every division runs on one shared restoring divider, one quotient bit per cycle, so a request takes on the order of a hundred cycles. The results then stay on the outputs until the next request completes.

Top module: `pll_freq_calc`

## Requirements
- R1: After reset `busy`, `done`, `pll_hz` and `bus_hz` are all 0.
- R2: A `start` seen while idle is accepted and `busy` is 1 in the next cycle. Completion is a single-cycle `done` pulse, and `pll_hz`/`bus_hz` take their new values in that cycle. Outside a `done` cycle both outputs hold their values.
- R3: A `start` that arrives while `busy` is 1 is ignored. The result reflects the inputs latched at acceptance.
- R4: The input clock is 25 000 000 Hz when `strap_25m` is 1. Otherwise it is 48 000 000 Hz when `strap_48m` is 1, and 24 000 000 Hz when neither strap is set.
- R5: When the off bit (`param_word[24]`) is 1, `pll_hz` and `bus_hz` are 0 in either mode. This check takes precedence over every other bit.
- R6: In M/N/P mode with the bypass bit (`param_word[20]`) clear, P = bits 18:13, M = bits 12:5 and N = bits 4:0. The multiplier is ((M+1)/(N+1))/(P+1), with each division truncating.
- R7: In programmed mode with the programmed bit (`param_word[21]`) set and bypass clear, N = bits 10:5, OD = bit 4 and D = bits 3:0. The multiplier is (2-OD)*((N+2)/(D+1)), with truncating division.
- R8: With bypass set (and, in programmed mode, the programmed bit set) the multiplier is 1, so `pll_hz` equals the input clock.
- R9: In programmed mode with the programmed bit clear, `pll_hz` = table[`strap_hsel`] MHz and the bypass bit is ignored. For a 25 MHz input the table is {400,375,350,425} for selects 0..3. For a 24 or 48 MHz input it is {384,360,336,408}.
- R10: `bus_hz` = (`pll_hz`/(`clksel_word[25:23]`+1)) / K, truncating. K is 2 in programmed mode and 4 in M/N/P mode.
- R11: When input clock times multiplier exceeds 32 bits, `pll_hz` saturates to 0xFFFFFFFF. The bus clock is then derived from the saturated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; inputs below latched when accepted |
| mode | input | 1 | 0 programmed layout, 1 M/N/P layout |
| param_word | input | 32 | PLL parameter word |
| clksel_word | input | 32 | Clock-select word holding the bus divider field |
| strap_25m | input | 1 | 25 MHz input-clock strap |
| strap_48m | input | 1 | 48 MHz input-clock strap |
| strap_hsel | input | 2 | Fixed-frequency table select |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| pll_hz | output | 32 | PLL output frequency in Hz |
| bus_hz | output | 32 | Peripheral bus clock frequency in Hz |

## Verification
The M/N/P path is driven with field sets that give large, unit and truncated multipliers under different straps. This shows whether the three fields sit at the right bit positions and whether the division happens in the right place. The programmed path is driven with OD at 0 and at 1 so that a doubled loop can be told apart from a plain one. Table lookups use every strap combination, which separates the 25 MHz row from the shared 24/48 MHz row. Off, bypass and a 48 MHz maximum multiplier cover the precedence order and saturation, and a `start` pulse issued mid-request shows that a running job is not overwritten.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DIV1,
    ST_DIV2,
    ST_MUL,
    ST_BUS,
    ST_DIV3
  } pllc_state_e;

  typedef enum logic {
    MODE_PROG = 1'b0,
    MODE_MNP  = 1'b1
  } pllc_mode_e;

  // Field positions of both parameter layouts (decoded by the unpack stage).
  localparam int MNP_P_LSB  = 13;
  localparam int MNP_P_W    = 6;
  localparam int MNP_M_LSB  = 5;
  localparam int MNP_M_W    = 8;
  localparam int MNP_N_LSB  = 0;
  localparam int MNP_N_W    = 5;
  localparam int PRG_N_LSB  = 5;
  localparam int PRG_N_W    = 6;
  localparam int PRG_OD_BIT = 4;
  localparam int PRG_D_LSB  = 0;
  localparam int PRG_D_W    = 4;

  // Bus post-divider expressed as a right shift per mode.
  localparam int SHIFT_PROG = 1;
  localparam int SHIFT_MNP  = 2;

  localparam int HZ_PER_MHZ = 1000000;

  typedef struct packed {
    logic [MNP_M_W-1:0] m;
    logic [MNP_N_W-1:0] n;
    logic [MNP_P_W-1:0] p;
    logic [PRG_N_W-1:0] pn;
    logic               od;
    logic [PRG_D_W-1:0] d;
  } pllc_fields_t;

  function automatic int unsigned pllc_table_mhz(input logic is25, input logic [1:0] sel);
    int unsigned base;
    case (sel)
      2'd0:    base = 384;
      2'd1:    base = 360;
      2'd2:    base = 336;
      default: base = 408;
    endcase
    // 25 MHz row equals the 24 MHz row scaled by 25/24.
    if (is25) base = (base * 25) / 24;
    return base;
  endfunction

endpackage

// File: rtl/pllc_clkin_sel.sv
module pllc_clkin_sel
  import pllc_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              strap_25m,
  input  logic              strap_48m,
  input  logic [1:0]        strap_hsel,
  output logic [FREQ_W-1:0] clkin_hz,
  output logic [FREQ_W-1:0] table_hz
);

  localparam logic [FREQ_W-1:0] HZ_24 = FREQ_W'(24 * HZ_PER_MHZ);
  localparam logic [FREQ_W-1:0] HZ_25 = FREQ_W'(25 * HZ_PER_MHZ);
  localparam logic [FREQ_W-1:0] HZ_48 = FREQ_W'(48 * HZ_PER_MHZ);

  always_comb begin
    if (strap_25m)      clkin_hz = HZ_25;
    else if (strap_48m) clkin_hz = HZ_48;
    else                clkin_hz = HZ_24;
  end

  always_comb begin
    table_hz = FREQ_W'(pllc_table_mhz(strap_25m, strap_hsel) * HZ_PER_MHZ);
  end

endmodule

// File: rtl/pllc_field_unpack.sv
module pllc_field_unpack
  import pllc_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int OFF_BIT    = 24,
  parameter int BYPASS_BIT = 20,
  parameter int PROG_BIT   = 21
) (
  input  logic [WORD_W-1:0] word,
  output pllc_fields_t      fields,
  output logic              off_flag,
  output logic              bypass_flag,
  output logic              prog_flag
);

  always_comb begin
    fields.m    = word[MNP_M_LSB +: MNP_M_W];
    fields.n    = word[MNP_N_LSB +: MNP_N_W];
    fields.p    = word[MNP_P_LSB +: MNP_P_W];
    fields.pn   = word[PRG_N_LSB +: PRG_N_W];
    fields.od   = word[PRG_OD_BIT];
    fields.d    = word[PRG_D_LSB +: PRG_D_W];
    off_flag    = word[OFF_BIT];
    bypass_flag = word[BYPASS_BIT];
    prog_flag   = word[PROG_BIT];
  end

endmodule

// File: rtl/pllc_rdiv.sv
module pllc_rdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     dvs_q, dvs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [W:0]       shifted;
  logic [W:0]       diff;
  logic             fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = shifted >= {1'b0, dvs_q};
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    done_d  = (cnt_q == CNT_W'(1));
    if (cnt_q == '0) begin
      if (start) begin
        rem_d = '0;
        quo_d = dividend;
        dvs_d = divisor;
        cnt_d = CNT_W'(W);
      end
    end else begin
      rem_d = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign quotient = quo_q;
  assign done     = done_q;

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pllc_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int WORD_W     = 32,
  parameter int OFF_BIT    = 24,
  parameter int BYPASS_BIT = 20,
  parameter int PROG_BIT   = 21,
  parameter int PDIV_LSB   = 23,
  parameter int PDIV_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [WORD_W-1:0] param_word,
  input  logic [WORD_W-1:0] clksel_word,
  input  logic              strap_25m,
  input  logic              strap_48m,
  input  logic [1:0]        strap_hsel,
  output logic              busy,
  output logic              done,
  output logic [FREQ_W-1:0] pll_hz,
  output logic [FREQ_W-1:0] bus_hz
);

  localparam int MULT_W = MNP_M_W + 1;
  localparam int PROD_W = FREQ_W + MULT_W;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pllc_state_e       state_q, state_d;
  pllc_mode_e        mode_q;
  logic [WORD_W-1:0] param_q, clksel_q;
  logic              s25_q, s48_q;
  logic [1:0]        hsel_q;
  logic              cap_en;
  logic [MULT_W-1:0] mult_q, mult_d;
  logic [FREQ_W-1:0] work_q, work_d;
  logic [FREQ_W-1:0] pll_q, pll_d;
  logic [FREQ_W-1:0] bus_q, bus_d;
  logic              done_q, done_d;

  logic              div_start;
  logic [FREQ_W-1:0] div_dvd, div_dvs, div_quo;
  logic              div_done;

  logic [FREQ_W-1:0] clkin_hz, table_hz;
  pllc_fields_t      fields;
  logic              off_flag, bypass_flag, prog_flag;
  logic [PROD_W-1:0] product;
  logic [FREQ_W-1:0] product_sat;
  logic [PDIV_W-1:0] pdiv;
  logic [FREQ_W-1:0] bus_shifted;

  assign cap_en = (state_q == ST_IDLE) && start;

  // Request capture.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q   <= MODE_PROG;
      param_q  <= '0;
      clksel_q <= '0;
      s25_q    <= 1'b0;
      s48_q    <= 1'b0;
      hsel_q   <= '0;
    end else if (cap_en) begin
      mode_q   <= pllc_mode_e'(mode);
      param_q  <= param_word;
      clksel_q <= clksel_word;
      s25_q    <= strap_25m;
      s48_q    <= strap_48m;
      hsel_q   <= strap_hsel;
    end
  end

  pllc_clkin_sel #(.FREQ_W(FREQ_W)) i_clkin (
    .strap_25m (s25_q),
    .strap_48m (s48_q),
    .strap_hsel(hsel_q),
    .clkin_hz  (clkin_hz),
    .table_hz  (table_hz)
  );

  pllc_field_unpack #(
    .WORD_W    (WORD_W),
    .OFF_BIT   (OFF_BIT),
    .BYPASS_BIT(BYPASS_BIT),
    .PROG_BIT  (PROG_BIT)
  ) i_unpack (
    .word       (param_q),
    .fields     (fields),
    .off_flag   (off_flag),
    .bypass_flag(bypass_flag),
    .prog_flag  (prog_flag)
  );

  pllc_rdiv #(.W(FREQ_W)) i_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (div_start),
    .dividend(div_dvd),
    .divisor (div_dvs),
    .quotient(div_quo),
    .done    (div_done)
  );

  // Saturating product of input clock and multiplier.
  assign product     = PROD_W'(clkin_hz) * PROD_W'(mult_q);
  assign product_sat = (|product[PROD_W-1:FREQ_W]) ? '1 : product[FREQ_W-1:0];
  assign pdiv        = clksel_q[PDIV_LSB +: PDIV_W];

  // Fixed bus post-divider chosen per mode.
  generate
    if (SHIFT_MNP != SHIFT_PROG) begin : g_mode_shift
      assign bus_shifted = (mode_q == MODE_MNP) ? (div_quo >> SHIFT_MNP)
                                                : (div_quo >> SHIFT_PROG);
    end else begin : g_same_shift
      assign bus_shifted = div_quo >> SHIFT_PROG;
    end
  endgenerate

  always_comb begin
    state_d   = state_q;
    mult_d    = mult_q;
    work_d    = work_q;
    pll_d     = pll_q;
    bus_d     = bus_q;
    done_d    = 1'b0;
    div_start = 1'b0;
    div_dvd   = '0;
    div_dvs   = '0;
    case (state_q)
      ST_IDLE: begin
        if (start) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (off_flag) begin
          work_d  = '0;
          state_d = ST_BUS;
        end else if ((mode_q == MODE_PROG) && !prog_flag) begin
          work_d  = table_hz;
          state_d = ST_BUS;
        end else if (bypass_flag) begin
          mult_d  = MULT_W'(1);
          state_d = ST_MUL;
        end else begin
          div_start = 1'b1;
          if (mode_q == MODE_MNP) begin
            div_dvd = FREQ_W'(fields.m) + FREQ_W'(1);
            div_dvs = FREQ_W'(fields.n) + FREQ_W'(1);
          end else begin
            div_dvd = FREQ_W'(fields.pn) + FREQ_W'(2);
            div_dvs = FREQ_W'(fields.d) + FREQ_W'(1);
          end
          state_d = ST_DIV1;
        end
      end
      ST_DIV1: begin
        if (div_done) begin
          if (mode_q == MODE_MNP) begin
            div_start = 1'b1;
            div_dvd   = div_quo;
            div_dvs   = FREQ_W'(fields.p) + FREQ_W'(1);
            state_d   = ST_DIV2;
          end else begin
            mult_d  = fields.od ? div_quo[MULT_W-1:0] : {div_quo[MULT_W-2:0], 1'b0};
            state_d = ST_MUL;
          end
        end
      end
      ST_DIV2: begin
        if (div_done) begin
          mult_d  = div_quo[MULT_W-1:0];
          state_d = ST_MUL;
        end
      end
      ST_MUL: begin
        work_d  = product_sat;
        state_d = ST_BUS;
      end
      ST_BUS: begin
        div_start = 1'b1;
        div_dvd   = work_q;
        div_dvs   = FREQ_W'(pdiv) + FREQ_W'(1);
        state_d   = ST_DIV3;
      end
      ST_DIV3: begin
        if (div_done) begin
          pll_d   = work_q;
          bus_d   = bus_shifted;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      mult_q  <= '0;
      work_q  <= '0;
      pll_q   <= '0;
      bus_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mult_q  <= mult_d;
      work_q  <= work_d;
      pll_q   <= pll_d;
      bus_q   <= bus_d;
      done_q  <= done_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign pll_hz = pll_q;
  assign bus_hz = bus_q;

endmodule

// File: rtl/pllc_checker.sv
module pllc_checker #(
  parameter int FREQ_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [FREQ_W-1:0] pll_hz,
  input logic [FREQ_W-1:0] bus_hz,
  input logic              div_start,
  input logic [FREQ_W-1:0] div_dvs,
  input logic              off_flag
);

  // R2: completion is a single-cycle pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: an idle start makes the block busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2/R3: results only move on a done cycle
  a_r3_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pll_hz) && $stable(bus_hz)));

  // R5: off bit forces zero results
  a_r5_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && off_flag) |-> (pll_hz == '0 && bus_hz == '0));

  // R10: bus clock never exceeds half the PLL clock
  a_r10_bus_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_hz <= (pll_hz >> 1)));

  // R10: divider never receives a zero divisor
  a_r10_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> (div_dvs != '0));

endmodule

bind pll_freq_calc pllc_checker #(.FREQ_W(FREQ_W)) i_pllc_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pll_hz   (pll_hz),
  .bus_hz   (bus_hz),
  .div_start(div_start),
  .div_dvs  (div_dvs),
  .off_flag (off_flag)
);

// File: tb/test_pll_freq_calc.sv
module test_pll_freq_calc;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        mode;
  logic [31:0] param_word;
  logic [31:0] clksel_word;
  logic        strap_25m;
  logic        strap_48m;
  logic [1:0]  strap_hsel;
  logic        busy;
  logic        done;
  logic [31:0] pll_hz;
  logic [31:0] bus_hz;

  int n_tests;
  int n_fail;

  pll_freq_calc i_pll_freq_calc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .param_word (param_word),
    .clksel_word(clksel_word),
    .strap_25m  (strap_25m),
    .strap_48m  (strap_48m),
    .strap_hsel (strap_hsel),
    .busy       (busy),
    .done       (done),
    .pll_hz     (pll_hz),
    .bus_hz     (bus_hz)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Word builders.
  function automatic logic [31:0] w_mnp(input int m, input int n, input int p,
                                        input logic off, input logic byp);
    logic [31:0] w;
    w = '0;
    w[12:5]  = m[7:0];
    w[4:0]   = n[4:0];
    w[18:13] = p[5:0];
    w[24]    = off;
    w[20]    = byp;
    return w;
  endfunction

  function automatic logic [31:0] w_prg(input int n, input logic od, input int d,
                                        input logic prg, input logic off, input logic byp);
    logic [31:0] w;
    w = '0;
    w[10:5] = n[5:0];
    w[4]    = od;
    w[3:0]  = d[3:0];
    w[21]   = prg;
    w[24]   = off;
    w[20]   = byp;
    return w;
  endfunction

  function automatic logic [31:0] w_sel(input int div);
    logic [31:0] w;
    w = 32'h5A00_00C3;
    w[25:23] = div[2:0];
    return w;
  endfunction

  // Reference model from the requirements.
  function automatic longint unsigned ref_clkin(input logic s25, input logic s48);
    if (s25) return 64'd25000000;
    if (s48) return 64'd48000000;
    return 64'd24000000;
  endfunction

  function automatic logic [31:0] ref_pll(input logic md, input logic [31:0] w,
                                          input logic s25, input logic s48, input logic [1:0] sel);
    longint unsigned mult;
    longint unsigned prod;
    int unsigned t24 [4];
    int unsigned t25 [4];
    t24 = '{384, 360, 336, 408};
    t25 = '{400, 375, 350, 425};
    if (w[24]) return 32'd0;
    if (!md && !w[21]) return s25 ? t25[sel] * 1000000 : t24[sel] * 1000000;
    if (w[20]) mult = 1;
    else if (md) mult = ((w[12:5] + 64'd1) / (w[4:0] + 64'd1)) / (w[18:13] + 64'd1);
    else mult = (64'd2 - w[4]) * ((w[10:5] + 64'd2) / (w[3:0] + 64'd1));
    prod = ref_clkin(s25, s48) * mult;
    if (prod > 64'hFFFF_FFFF) return 32'hFFFF_FFFF;
    return prod[31:0];
  endfunction

  function automatic logic [31:0] ref_bus(input logic md, input logic [31:0] pll, input logic [31:0] cs);
    logic [31:0] q;
    q = pll / (cs[25:23] + 32'd1);
    return md ? (q / 4) : (q / 2);
  endfunction

  task automatic pulse_start(input logic md, input logic [31:0] w, input logic [31:0] cs,
                             input logic s25, input logic s48, input logic [1:0] sel);
    @(negedge clk);
    mode = md; param_word = w; clksel_word = cs;
    strap_25m = s25; strap_48m = s48; strap_hsel = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL %s actual=no done expected=done", req);
    end
  endtask

  task automatic run_case(input string req, input logic md, input logic [31:0] w,
                          input logic [31:0] cs, input logic s25, input logic s48,
                          input logic [1:0] sel);
    logic [31:0] ep;
    ep = ref_pll(md, w, s25, s48, sel);
    pulse_start(md, w, cs, s25, s48, sel);
    check({req, " busy after start (R2)"}, {31'd0, busy}, 32'd1);
    wait_done(req);
    check({req, " pll_hz"}, pll_hz, ep);
    check({req, " bus_hz (R10)"}, bus_hz, ref_bus(md, ep, cs));
  endtask

  task automatic t_reset;
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 pll_hz", pll_hz, 32'd0);
    check("R1 bus_hz", bus_hz, 32'd0);
  endtask

  task automatic t_mnp;
    run_case("R6 mnp a", 1'b1, w_mnp(159, 1, 0, 0, 0), w_sel(0), 0, 0, 2'd0);
    run_case("R6 mnp b", 1'b1, w_mnp(100, 6, 2, 0, 0), w_sel(3), 0, 1, 2'd1);
    run_case("R6 mnp c", 1'b1, w_mnp(47, 3, 1, 0, 0), w_sel(7), 1, 0, 2'd3);
    check("R6 mnp c exact", pll_hz, 32'd150000000);
  endtask

  task automatic t_prog;
    run_case("R7 prog od0", 1'b0, w_prg(30, 0, 3, 1, 0, 0), w_sel(1), 1, 0, 2'd0);
    check("R7 prog od0 exact", pll_hz, 32'd400000000);
    run_case("R7 prog od1", 1'b0, w_prg(10, 1, 2, 1, 0, 0), w_sel(2), 0, 1, 2'd2);
    check("R7 prog od1 exact", pll_hz, 32'd192000000);
  endtask

  task automatic t_table;
    run_case("R9 table 25 sel3", 1'b0, w_prg(5, 0, 0, 0, 0, 1), w_sel(0), 1, 1, 2'd3);
    check("R9 25MHz row", pll_hz, 32'd425000000);
    run_case("R9 table 24 sel1", 1'b0, w_prg(0, 0, 0, 0, 0, 0), w_sel(4), 0, 0, 2'd1);
    check("R9 24MHz row", pll_hz, 32'd360000000);
    run_case("R9 table 48 sel2", 1'b0, w_prg(0, 1, 7, 0, 0, 0), w_sel(5), 0, 1, 2'd2);
    check("R9 48MHz row", pll_hz, 32'd336000000);
  endtask

  task automatic t_clkin_bypass;
    run_case("R8 bypass mnp 24", 1'b1, w_mnp(200, 0, 0, 0, 1), w_sel(0), 0, 0, 2'd0);
    check("R4 clkin 24", pll_hz, 32'd24000000);
    run_case("R8 bypass prog 48", 1'b0, w_prg(63, 0, 0, 1, 0, 1), w_sel(2), 0, 1, 2'd0);
    check("R4 clkin 48", pll_hz, 32'd48000000);
    run_case("R8 bypass mnp 25", 1'b1, w_mnp(0, 0, 0, 0, 1), w_sel(1), 1, 1, 2'd0);
    check("R4 clkin 25 priority", pll_hz, 32'd25000000);
  endtask

  task automatic t_off;
    run_case("R5 off mnp", 1'b1, w_mnp(159, 1, 0, 1, 1), w_sel(0), 0, 1, 2'd0);
    check("R5 off mnp zero", pll_hz, 32'd0);
    run_case("R5 off prog table", 1'b0, w_prg(0, 0, 0, 0, 1, 0), w_sel(0), 1, 0, 2'd3);
    check("R5 off prog zero", bus_hz, 32'd0);
  endtask

  task automatic t_sat;
    run_case("R11 sat mnp", 1'b1, w_mnp(255, 0, 0, 0, 0), w_sel(2), 0, 1, 2'd0);
    check("R11 saturated", pll_hz, 32'hFFFF_FFFF);
    run_case("R11 sat prog", 1'b0, w_prg(63, 0, 0, 1, 0, 0), w_sel(0), 0, 1, 2'd0);
    check("R11 saturated prog", pll_hz, 32'hFFFF_FFFF);
  endtask

  task automatic t_busy_start;
    logic [31:0] ep;
    logic [31:0] hp;
    logic [31:0] hb;
    ep = ref_pll(1'b1, w_mnp(99, 4, 0, 0, 0), 0, 0, 2'd0);
    pulse_start(1'b1, w_mnp(99, 4, 0, 0, 0), w_sel(1), 0, 0, 2'd0);
    repeat (5) @(negedge clk);
    check("R3 busy mid request", {31'd0, busy}, 32'd1);
    pulse_start(1'b0, w_prg(0, 0, 0, 0, 0, 0), w_sel(0), 1, 0, 2'd3);
    wait_done("R3 ignored start");
    check("R3 pll from first request", pll_hz, ep);
    check("R3 bus from first request", bus_hz, ref_bus(1'b1, ep, w_sel(1)));
    hp = pll_hz;
    hb = bus_hz;
    repeat (3) @(negedge clk);
    check("R2 done pulse ends", {31'd0, done}, 32'd0);
    check("R3 no second request", {31'd0, busy}, 32'd0);
    check("R2 pll holds", pll_hz, hp);
    check("R2 bus holds", bus_hz, hb);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n = 1'b0;
    start = 1'b0;
    mode = 1'b0;
    param_word = '0;
    clksel_word = '0;
    strap_25m = 1'b0;
    strap_48m = 1'b0;
    strap_hsel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mnp();
    t_prog();
    t_table();
    t_clkin_bypass();
    t_off();
    t_sat();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule